// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between the command scheduler of an SDRAM controller and the memory pins. For each cycle it looks at the command the scheduler wants to issue, the target bank, and a strobe that marks the last beat of write data. It then raises a grant for each command type only when every minimum interval that applies to that command has elapsed. The grants are combinational, so the scheduler can look at them and issue in the same cycle. A command that arrives without its grant is refused. A refused command changes no timing state, and the block flags a violation one cycle later. The block also flags a row that has stayed open longer than the maximum row-active time.

Interval limits are parameters. The analog limits are given in nanoseconds and the clock period in picoseconds. At elaboration each analog limit is converted to a whole number of clocks by dividing by the period and rounding any fraction up. The limits defined in clocks (write-data recovery, burst-stop delay, CAS latency) are parameters given directly in cycles. With the defaults and a 20 ns clock, the conversions are: row cycle time 62 ns becomes 4 clocks, minimum row-active time 42 ns becomes 3, maximum row-active time 100,000 ns becomes 5000, precharge time 20 ns becomes 1, activate-to-column delay 20 ns becomes 1, and bank-to-bank activate spacing 14 ns becomes 1.

Top module: `sdram_timing_guard`

## Requirements
- R1: Two ACTIVE commands to the same bank are at least ceil(T_RC_NS*1000/CLK_PS) cycles apart. With the defaults this is 4 cycles: after ACTIVE in cycle t, the grant reappears no earlier than cycle t+4, and only once the row is closed again.
- R2: Any two ACTIVE commands, to any banks, are at least ceil(T_RRD_NS*1000/CLK_PS) cycles apart.
- R3: After a PRECHARGE that closes an open row, ACTIVE to that bank waits ceil(T_RP_NS*1000/CLK_PS) cycles.
- R4: READ and WRITE are granted only to an open bank, and only ceil(T_RCD_NS*1000/CLK_PS) or more cycles after its ACTIVE.
- R5: PRECHARGE of an open bank waits ceil(T_RAS_MIN_NS*1000/CLK_PS) cycles after its ACTIVE. PRECHARGE of a closed bank is allowed and starts no timer.
- R6: PRECHARGE is granted only T_DPL_CK or more cycles after the last-write-data strobe, and BURST STOP only T_BDL_CK or more cycles after it. A strobe in the current cycle counts as distance 0.
- R7: A granted PRECHARGE issued while the most recent granted column command was a READ blocks WRITE for CAS_LAT cycles. That PRECHARGE may target any bank, and it ends the read state.
- R8: AUTO REFRESH is granted only when no bank is open and no bank has a row-cycle or precharge interval still running. A granted refresh starts the row-cycle interval on every bank.
- R9: Command encoding on `cmd` is 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST STOP, 6 AUTO REFRESH, 7 reserved (treated as NOP). Codes 1 to 6 issued without their grant change no state and pulse `viol` in the next cycle. Codes 0 and 7 never cause a violation.
- R10: If a row is still open in the cycle that is ceil(T_RAS_MAX_NS*1000/CLK_PS)+1 cycles after its ACTIVE, `viol` pulses for one cycle, once per opening.
- R11: After reset all banks are closed. ACTIVE, PRECHARGE, BURST STOP and AUTO REFRESH are granted, READ and WRITE are not, and `viol` is low.
- R12: Column commands to an open bank may be issued on consecutive cycles; READ and WRITE add no spacing between themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Requested command code |
| bank | input | $clog2(NBANK) | Target bank of the command |
| wr_last | input | 1 | Last write-data beat is on the bus this cycle |
| gnt_act | output | 1 | ACTIVE to `bank` is allowed now |
| gnt_rd | output | 1 | READ to `bank` is allowed now |
| gnt_wr | output | 1 | WRITE to `bank` is allowed now |
| gnt_pre | output | 1 | PRECHARGE to `bank` is allowed now |
| gnt_bst | output | 1 | BURST STOP is allowed now |
| gnt_ref | output | 1 | AUTO REFRESH is allowed now |
| viol | output | 1 | Registered pulse: a refused command or an over-long open row in the previous cycle |

## Verification
The situation hardest to reach from the ports is the maximum row-active expiry. It needs a row held open for about five thousand cycles with no PRECHARGE to that bank. Random traffic closes rows long before that. A directed phase therefore opens one bank, then drives only NOPs and traffic to other banks past the limit. The bench expects exactly one violation pulse in the cycle after the limit and none afterwards. The bus-release rule is also hard to reach by chance, because it needs a READ followed by a PRECHARGE and then an early WRITE to another open bank. A directed sequence builds that pattern. The random phase then often issues commands that would be refused, which exercises the rule that a refused command has no effect.

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard #(
  parameter int CLK_PS       = 20000,
  parameter int T_RC_NS      = 62,
  parameter int T_RAS_MIN_NS = 42,
  parameter int T_RAS_MAX_NS = 100000,
  parameter int T_RP_NS      = 20,
  parameter int T_RCD_NS     = 20,
  parameter int T_RRD_NS     = 14,
  parameter int T_DPL_CK     = 2,
  parameter int T_BDL_CK     = 1,
  parameter int CAS_LAT      = 3,
  parameter int NBANK        = 4,
  localparam int BW          = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic          wr_last,
  output logic          gnt_act,
  output logic          gnt_rd,
  output logic          gnt_wr,
  output logic          gnt_pre,
  output logic          gnt_bst,
  output logic          gnt_ref,
  output logic          viol
);

  function automatic int to_ck(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int reload(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  localparam int RC_CK  = to_ck(T_RC_NS);
  localparam int RAS_CK = to_ck(T_RAS_MIN_NS);
  localparam int RMX_CK = to_ck(T_RAS_MAX_NS);
  localparam int RP_CK  = to_ck(T_RP_NS);
  localparam int RCD_CK = to_ck(T_RCD_NS);
  localparam int RRD_CK = to_ck(T_RRD_NS);
  localparam int CW = $clog2(RC_CK + RAS_CK + RP_CK + RCD_CK + RRD_CK + T_DPL_CK + T_BDL_CK + CAS_LAT + 1);
  localparam int AW = $clog2(RMX_CK + 2);

  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_BST = 3'd5, C_REF = 3'd6;

  logic [NBANK-1:0] open_q;
  logic [CW-1:0]    rc_q [NBANK];
  logic [CW-1:0]    ras_q[NBANK];
  logic [CW-1:0]    rp_q [NBANK];
  logic [CW-1:0]    rcd_q[NBANK];
  logic [AW-1:0]    age_q[NBANK];
  logic [CW-1:0]    rrd_q, dpl_q, bdl_q, roh_q;
  logic             rd_last_q;

  logic bo, all_idle, expire, granted, is_cmd, go;
  logic act_go, rd_go, wr_go, pre_go, ref_go;

  assign bo = open_q[bank];

  assign gnt_act = !bo && rc_q[bank] == '0 && rp_q[bank] == '0 && rrd_q == '0;
  assign gnt_rd  = bo && rcd_q[bank] == '0;
  assign gnt_wr  = bo && rcd_q[bank] == '0 && roh_q == '0;
  assign gnt_pre = (!bo || ras_q[bank] == '0) && dpl_q == '0 && (T_DPL_CK == 0 || !wr_last);
  assign gnt_bst = bdl_q == '0 && (T_BDL_CK == 0 || !wr_last);
  assign gnt_ref = all_idle;

  always_comb begin
    case (cmd)
      C_ACT:   granted = gnt_act;
      C_RD:    granted = gnt_rd;
      C_WR:    granted = gnt_wr;
      C_PRE:   granted = gnt_pre;
      C_BST:   granted = gnt_bst;
      C_REF:   granted = gnt_ref;
      default: granted = 1'b1;
    endcase
  end

  assign is_cmd = cmd != 3'd0 && cmd != 3'd7;
  assign go     = is_cmd && granted;
  assign act_go = go && cmd == C_ACT;
  assign rd_go  = go && cmd == C_RD;
  assign wr_go  = go && cmd == C_WR;
  assign pre_go = go && cmd == C_PRE;
  assign ref_go = go && cmd == C_REF;

  always_comb begin
    all_idle = 1'b1;
    expire   = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (open_q[b] || rc_q[b] != '0 || rp_q[b] != '0) all_idle = 1'b0;
      if (open_q[b] && age_q[b] == AW'(RMX_CK) && !(pre_go && bank == BW'(b))) expire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= '0;
      rrd_q     <= '0;
      dpl_q     <= '0;
      bdl_q     <= '0;
      roh_q     <= '0;
      rd_last_q <= 1'b0;
      viol      <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        rc_q[b]  <= '0;
        ras_q[b] <= '0;
        rp_q[b]  <= '0;
        rcd_q[b] <= '0;
        age_q[b] <= '0;
      end
    end else begin
      viol <= (is_cmd && !granted) || expire;
      if (rrd_q != '0) rrd_q <= rrd_q - 1'b1;
      if (dpl_q != '0) dpl_q <= dpl_q - 1'b1;
      if (bdl_q != '0) bdl_q <= bdl_q - 1'b1;
      if (roh_q != '0) roh_q <= roh_q - 1'b1;
      for (int b = 0; b < NBANK; b++) begin
        if (rc_q[b]  != '0) rc_q[b]  <= rc_q[b]  - 1'b1;
        if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
        if (rp_q[b]  != '0) rp_q[b]  <= rp_q[b]  - 1'b1;
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
        if (open_q[b] && age_q[b] <= AW'(RMX_CK)) age_q[b] <= age_q[b] + 1'b1;
        if (ref_go) rc_q[b] <= CW'(reload(RC_CK));
      end
      if (act_go) begin
        open_q[bank] <= 1'b1;
        rc_q[bank]   <= CW'(reload(RC_CK));
        ras_q[bank]  <= CW'(reload(RAS_CK));
        rcd_q[bank]  <= CW'(reload(RCD_CK));
        age_q[bank]  <= AW'(1);
        rrd_q        <= CW'(reload(RRD_CK));
      end
      if (rd_go) rd_last_q <= 1'b1;
      if (wr_go) rd_last_q <= 1'b0;
      if (pre_go) begin
        if (bo) begin
          open_q[bank] <= 1'b0;
          rp_q[bank]   <= CW'(reload(RP_CK));
        end
        if (rd_last_q) begin
          roh_q     <= CW'(reload(CAS_LAT));
          rd_last_q <= 1'b0;
        end
      end
      if (wr_last) begin
        dpl_q <= CW'(reload(T_DPL_CK));
        bdl_q <= CW'(reload(T_BDL_CK));
      end
    end
  end

  initial AST_CAS_LAT_RANGE: assert (CAS_LAT == 2 || CAS_LAT == 3); // R7

  AST_SAME_BANK_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (bank != $past(bank) || !gnt_act)); // R1

  AST_REF_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> !gnt_ref); // R8

  AST_CLOSED_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_go && bo) |=> (bank != $past(bank) || (!gnt_rd && !gnt_wr))); // R4

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && !gnt_rd) |=> viol); // R9

  AST_QUIET_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_cmd && !expire) |=> !viol); // R9

  generate
    if (T_DPL_CK > 1) begin : g_dpl
      AST_DPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |=> !gnt_pre); // R6
    end
  endgenerate

endmodule

// File: tb/tb_sdram_timing_guard.sv
`timescale 1ns/1ps
module tb_sdram_timing_guard;
  localparam int PER_PS = 20000;
  localparam int NB = 4;

  function automatic int cyc_of(input int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  localparam int RC = cyc_of(62), RASN = cyc_of(42), RASX = cyc_of(100000);
  localparam int RP = cyc_of(20), RCD = cyc_of(20), RRD = cyc_of(14);
  localparam int DPL = 2, BDL = 1, CL = 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd = 0;
  logic [1:0] bank = 0;
  logic wr_last = 0;
  logic gnt_act, gnt_rd, gnt_wr, gnt_pre, gnt_bst, gnt_ref, viol;

  sdram_timing_guard dut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .wr_last(wr_last),
    .gnt_act(gnt_act), .gnt_rd(gnt_rd), .gnt_wr(gnt_wr), .gnt_pre(gnt_pre),
    .gnt_bst(gnt_bst), .gnt_ref(gnt_ref), .viol(viol));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint last_act[NB], last_pre[NB];
  longint last_wl, last_any, last_roh;
  bit open_m[NB];
  bit rd_m, exp_viol;

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  function automatic bit mg(input int c, input int b, input bit w);
    bit idle;
    case (c)
      1: return !open_m[b] && cyc - last_act[b] >= RC && cyc - last_pre[b] >= RP && cyc - last_any >= RRD;
      2: return open_m[b] && cyc - last_act[b] >= RCD;
      3: return open_m[b] && cyc - last_act[b] >= RCD && cyc - last_roh >= CL;
      4: return (!open_m[b] || cyc - last_act[b] >= RASN) && !w && cyc - last_wl >= DPL;
      5: return !w && cyc - last_wl >= BDL;
      6: begin
        idle = 1;
        for (int i = 0; i < NB; i++)
          if (open_m[i] || cyc - last_act[i] < RC || cyc - last_pre[i] < RP) idle = 0;
        return idle;
      end
      default: return 1;
    endcase
  endfunction

  task automatic step(input int c, input int b, input bit w);
    bit g, nv;
    @(negedge clk);
    cmd = 3'(c); bank = 2'(b); wr_last = w;
    #2;
    chk(gnt_act, mg(1, b, w), "R1 R2 R3 gnt_act");
    chk(gnt_rd,  mg(2, b, w), "R4 R12 gnt_rd");
    chk(gnt_wr,  mg(3, b, w), "R4 R7 gnt_wr");
    chk(gnt_pre, mg(4, b, w), "R5 R6 gnt_pre");
    chk(gnt_bst, mg(5, b, w), "R6 gnt_bst");
    chk(gnt_ref, mg(6, b, w), "R8 gnt_ref");
    chk(viol, exp_viol, "R9 R10 viol");
    g = mg(c, b, w);
    nv = (c >= 1 && c <= 6 && !g);
    for (int i = 0; i < NB; i++)
      if (open_m[i] && cyc - last_act[i] == RASX && !(g && c == 4 && b == i)) nv = 1;
    exp_viol = nv;
    if (g) begin
      case (c)
        1: begin open_m[b] = 1; last_act[b] = cyc; last_any = cyc; end
        2: rd_m = 1;
        3: rd_m = 0;
        4: begin
          if (open_m[b]) begin open_m[b] = 0; last_pre[b] = cyc; end
          if (rd_m) begin last_roh = cyc; rd_m = 0; end
        end
        6: for (int i = 0; i < NB; i++) last_act[i] = cyc;
        default: ;
      endcase
    end
    if (w) last_wl = cyc;
    cyc++;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int c, b;
    void'($urandom(32'd7211));
    for (int i = 0; i < NB; i++) begin
      last_act[i] = -1000000; last_pre[i] = -1000000; open_m[i] = 0;
    end
    last_wl = -1000000; last_any = -1000000; last_roh = -1000000; rd_m = 0; exp_viol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk(gnt_act, 1, "R11 reset act"); chk(gnt_rd, 0, "R11 reset rd");
    chk(gnt_wr, 0, "R11 reset wr");   chk(gnt_pre, 1, "R11 reset pre");
    chk(gnt_bst, 1, "R11 reset bst"); chk(gnt_ref, 1, "R11 reset ref");
    chk(viol, 0, "R11 reset viol");
    // R1 R2 R5 R9: early commands on a fresh row
    step(1, 0, 0); step(1, 0, 0); step(4, 0, 0); step(1, 1, 0);
    step(2, 0, 0); step(3, 0, 0); step(2, 1, 0); step(0, 0, 0); step(7, 2, 0);
    // R7 R12: read, precharge, then early writes to another bank
    step(4, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    step(3, 1, 0); step(3, 1, 0); step(3, 1, 0); step(3, 1, 0);
    // R6: write-data strobe against precharge and burst stop
    step(3, 1, 1); step(4, 1, 0); step(5, 0, 0); step(4, 1, 0); step(5, 0, 1); step(5, 0, 0);
    // R8: refresh attempts with rows open, then after closing all
    step(6, 0, 0); step(4, 0, 0); step(4, 1, 0); step(6, 0, 0); step(1, 2, 0); step(6, 0, 0);
    step(0, 0, 0); step(1, 2, 0); step(1, 2, 0); step(1, 2, 0); step(1, 2, 0);
    // R10: hold bank 2 open past the maximum row time
    for (int k = 0; k < RASX + 6; k++) step((k % 7 == 0) ? 1 : 0, (k % 7 == 0) ? 3 : 0, 0);
    step(4, 3, 0); step(4, 2, 0); step(0, 0, 0);
    // random mix
    for (int k = 0; k < 6000; k++) begin
      c = $urandom_range(0, 9);
      c = (c < 3) ? 0 : (c == 9) ? 7 : c - 2;
      b = $urandom_range(0, NB - 1);
      if ($urandom_range(0, 99) < 80 && !mg(c, b, 0)) c = 0;
      step(c, b, $urandom_range(0, 99) < 15);
    end
    step(0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule